// File: doc/BRIEF.md
# Keyed Oscillator Configuration Register Bank

This block is a small register bank for the configuration of a ring-oscillator clock source. Software reaches it over a simple synchronous bus with an address, a write strobe, write data and registered read data. The bank holds an enable code, a frequency-range code that sets how many ring stages are active, and two drive-strength registers that cover eight stages. Its outputs go straight to the oscillator. They are a decoded enable, an active-stage count and a drive level for each stage.

Every protected value is checked when it is written. An enable or range code that is not in the legal set is replaced by a safe fallback: the oscillator stays enabled and the range falls back to the slowest one. A drive-strength write without the correct key clears all four stage fields of that register. Each of these cases also sets a sticky error flag in the status word, and software clears the flag explicitly. The status word also reports whether the oscillator is enabled and whether it has been running long enough to count as stable.

Top module: `osc_cfg_regs`

## Requirements
- R1: After reset the oscillator is enabled and the stage count is 8. Every drive level is 0, the error flag (status bit 24) is 0, and the control word reads 0x00FABFA4.
- R2: Control bits 23:12 hold the enable code. 0xD1E disables the oscillator and 0xFAB enables it. Any other value enables it, reads back as 0xFAB and sets the error flag.
- R3: Control bits 11:0 hold the range code. 0xFA4 gives 8 active stages, 0xFA5 gives 6, 0xFA7 gives 4 and 0xFA6 gives 2, and the stored code reads back unchanged.
- R4: An unknown range code selects 8 stages, reads back as 0xFA4 and sets the error flag.
- R5: The drive register at offset 0x08 covers stages 0 to 3 and the one at offset 0x0C covers stages 4 to 7. A write whose key in bits 31:16 equals 0x9696 stores the 3-bit fields at bits 2:0, 6:4, 10:8 and 14:12 (lowest stage in the lowest field). The drive word reads back with those fields and 0 in every other bit.
- R6: The drive level of a stage is the number of set bits in its field (0 to 3). Output drive_lvl_o carries stage i at bits [2i+1:2i].
- R7: A drive write with any other key clears all four fields of the addressed register, leaves the other drive register unchanged and sets the error flag.
- R8: The error flag is sticky. A write to status (offset 0x04) with bit 24 set clears it. A status write with bit 24 clear leaves it unchanged.
- R9: Status bits 12 and 16 report that the oscillator is enabled. Status bit 31 becomes 1 once the oscillator has been enabled without a break for STABLE_CYC cycles. It is 0 whenever the oscillator is disabled.
- R10: Read data is registered. A read returns the register value from before any write in the same cycle. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the address of the previous cycle |
| osc_en_o | output | 1 | Decoded oscillator enable |
| stage_cnt_o | output | CNT_W | Number of active ring stages |
| drive_lvl_o | output | NUM_STAGES*2 | Drive level of each stage |

## Verification
Two functions can fall in the same cycle: a register read and a write to that same register, because read and write share one address. The bench provokes this in two places. First, it writes an illegal range code to the control register while reading it, and expects the old code in that read and the fallback code in the next read. Second, it clears the error flag while reading status, and expects the flag still set in that read and clear in the following one. The scoreboard queues each expected read word at the moment the request is driven and compares it one edge later.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EN_CODE_ON  = 12'hFAB;
  localparam logic [CODE_W-1:0] EN_CODE_OFF = 12'hD1E;

  localparam logic [CODE_W-1:0] RNG_CODE_LOW  = 12'hFA4;
  localparam logic [CODE_W-1:0] RNG_CODE_MED  = 12'hFA5;
  localparam logic [CODE_W-1:0] RNG_CODE_HIGH = 12'hFA7;
  localparam logic [CODE_W-1:0] RNG_CODE_TOP  = 12'hFA6;

  typedef enum logic [1:0] {
    RANGE_LOW  = 2'd0,
    RANGE_MED  = 2'd1,
    RANGE_HIGH = 2'd2,
    RANGE_TOP  = 2'd3
  } range_e;

  localparam int OFS_CTRL = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_DRV0 = 'h8;
  localparam int OFS_STEP = 4;

  localparam int STAT_STABLE_BIT = 31;
  localparam int STAT_BAD_BIT    = 24;
  localparam int STAT_RUN_BIT    = 16;
  localparam int STAT_EN_BIT     = 12;

  function automatic logic [CODE_W-1:0] range_to_code(input range_e r);
    case (r)
      RANGE_MED:  return RNG_CODE_MED;
      RANGE_HIGH: return RNG_CODE_HIGH;
      RANGE_TOP:  return RNG_CODE_TOP;
      default:    return RNG_CODE_LOW;
    endcase
  endfunction

endpackage

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_cfg_pkg::*;
#(
  parameter int NUM_STAGES = 8,
  localparam int CNT_W = $clog2(NUM_STAGES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] en_code_i,
  input  logic [CODE_W-1:0] rng_code_i,
  output logic [CODE_W-1:0] en_code_o,
  output logic [CODE_W-1:0] rng_code_o,
  output logic              osc_en_o,
  output logic [CNT_W-1:0]  stage_cnt_o,
  output logic              bad_o
);

  logic   en_q, en_nxt;
  range_e rng_q, rng_nxt;
  logic   bad_en, bad_rng;

  // next-state: decode codes, apply fallbacks
  always_comb begin
    en_nxt  = en_q;
    rng_nxt = rng_q;
    bad_en  = 1'b0;
    bad_rng = 1'b0;
    if (wr_i) begin
      case (en_code_i)
        EN_CODE_OFF: en_nxt = 1'b0;
        EN_CODE_ON:  en_nxt = 1'b1;
        default: begin
          en_nxt = 1'b1;
          bad_en = 1'b1;
        end
      endcase
      case (rng_code_i)
        RNG_CODE_LOW:  rng_nxt = RANGE_LOW;
        RNG_CODE_MED:  rng_nxt = RANGE_MED;
        RNG_CODE_HIGH: rng_nxt = RANGE_HIGH;
        RNG_CODE_TOP:  rng_nxt = RANGE_TOP;
        default: begin
          rng_nxt = RANGE_LOW;
          bad_rng = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      en_q  <= 1'b1;
      rng_q <= RANGE_LOW;
    end else if (wr_i) begin
      en_q  <= en_nxt;
      rng_q <= rng_nxt;
    end
  end

  always_comb begin
    case (rng_q)
      RANGE_MED:  stage_cnt_o = CNT_W'((NUM_STAGES * 3) / 4);
      RANGE_HIGH: stage_cnt_o = CNT_W'(NUM_STAGES / 2);
      RANGE_TOP:  stage_cnt_o = CNT_W'(NUM_STAGES / 4);
      default:    stage_cnt_o = CNT_W'(NUM_STAGES);
    endcase
  end

  assign osc_en_o   = en_q;
  assign en_code_o  = en_q ? EN_CODE_ON : EN_CODE_OFF;
  assign rng_code_o = range_to_code(rng_q);
  assign bad_o      = wr_i & (bad_en | bad_rng);

  assert_disable_code_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && en_code_i == EN_CODE_OFF) |=> !osc_en_o);

  assert_other_code_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && en_code_i != EN_CODE_OFF) |=> osc_en_o);

  assert_bad_range_low_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && rng_code_i != RNG_CODE_LOW && rng_code_i != RNG_CODE_MED &&
     rng_code_i != RNG_CODE_HIGH && rng_code_i != RNG_CODE_TOP)
    |=> (stage_cnt_o == CNT_W'(NUM_STAGES)));

  assert_ctrl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !wr_i |=> ($stable(stage_cnt_o) && $stable(osc_en_o)));

endmodule

// File: rtl/osc_drive_reg.sv
module osc_drive_reg #(
  parameter int          STAGES  = 4,
  parameter int          FIELD_W = 3,
  parameter int          KEY_W   = 16,
  parameter logic [15:0] KEY     = 16'h9696,
  localparam int LVL_W = $clog2(FIELD_W + 1),
  localparam int FLD_W = STAGES * FIELD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic                    wr_i,
  input  logic [KEY_W-1:0]        key_i,
  input  logic [FLD_W-1:0]        fld_i,
  output logic [FLD_W-1:0]        fld_o,
  output logic [STAGES*LVL_W-1:0] lvl_o,
  output logic                    bad_o
);

  logic [FLD_W-1:0] fld_q, fld_nxt;
  logic             key_ok;

  assign key_ok = (key_i == KEY_W'(KEY));

  always_comb begin
    fld_nxt = fld_q;
    if (wr_i) fld_nxt = key_ok ? fld_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  fld_q <= '0;
    else if (wr_i) fld_q <= fld_nxt;
  end

  // per-stage level = population count of the field
  for (genvar s = 0; s < STAGES; s++) begin : g_lvl
    always_comb begin
      lvl_o[s*LVL_W +: LVL_W] = '0;
      for (int b = 0; b < FIELD_W; b++)
        lvl_o[s*LVL_W +: LVL_W] = lvl_o[s*LVL_W +: LVL_W] + LVL_W'(fld_q[s*FIELD_W + b]);
    end
  end

  assign fld_o = fld_q;
  assign bad_o = wr_i & ~key_ok;

  assert_bad_key_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && key_i != KEY_W'(KEY)) |=> (fld_o == '0));

  assert_good_key_stores_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_i && key_i == KEY_W'(KEY)) |=> (fld_o == $past(fld_i)));

  assert_drive_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !wr_i |=> $stable(fld_o));

endmodule

// File: rtl/osc_status.sv
module osc_status #(
  parameter int STABLE_CYC = 16,
  localparam int STB_W = $clog2(STABLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic osc_en_i,
  input  logic bad_evt_i,
  input  logic clr_i,
  output logic bad_flag_o,
  output logic stable_o
);

  logic             bad_q, bad_nxt;
  logic [STB_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_full;

  assign cnt_full = (cnt_q == STB_W'(STABLE_CYC));

  always_comb begin
    bad_nxt = bad_q;
    if (bad_evt_i)  bad_nxt = 1'b1;
    else if (clr_i) bad_nxt = 1'b0;
  end

  always_comb begin
    if (!osc_en_i)     cnt_nxt = '0;
    else if (cnt_full) cnt_nxt = cnt_q;
    else               cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      bad_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (bad_evt_i || clr_i) bad_q <= bad_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign bad_flag_o = bad_q;
  assign stable_o   = cnt_full & osc_en_i;

  assert_flag_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bad_evt_i |=> bad_flag_o);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (bad_flag_o && !bad_evt_i && !clr_i) |=> bad_flag_o);

  assert_stable_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stable_o |-> osc_en_i);

endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_cfg_pkg::*;
#(
  parameter int          ADDR_W         = 4,
  parameter int          NUM_STAGES     = 8,
  parameter int          STAGES_PER_REG = 4,
  parameter int          FIELD_W        = 3,
  parameter int          FIELD_STRIDE   = 4,
  parameter int          KEY_W          = 16,
  parameter logic [15:0] DRV_KEY        = 16'h9696,
  parameter int          STABLE_CYC     = 16,
  localparam int NUM_DRV = NUM_STAGES / STAGES_PER_REG,
  localparam int LVL_W   = $clog2(FIELD_W + 1),
  localparam int CNT_W   = $clog2(NUM_STAGES + 1),
  localparam int FLD_W   = STAGES_PER_REG * FIELD_W
) (
  input  logic                        clk_i,
  input  logic                        rst_n_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        wr_en_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic                        osc_en_o,
  output logic [CNT_W-1:0]            stage_cnt_o,
  output logic [NUM_STAGES*LVL_W-1:0] drive_lvl_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  // address decode
  logic               hit_ctrl, hit_stat, mapped;
  logic [NUM_DRV-1:0] hit_drv;
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  for (genvar g = 0; g < NUM_DRV; g++) begin : g_dec
    assign hit_drv[g] = (addr_i == ADDR_W'(OFS_DRV0 + OFS_STEP * g));
  end
  assign mapped = hit_ctrl | hit_stat | (|hit_drv);

  // control register
  logic [CODE_W-1:0] en_code, rng_code;
  logic              ctrl_bad;

  osc_ctrl_reg #(.NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n),
    .wr_i       (wr_en_i & hit_ctrl),
    .en_code_i  (wdata_i[2*CODE_W-1:CODE_W]),
    .rng_code_i (wdata_i[CODE_W-1:0]),
    .en_code_o  (en_code),
    .rng_code_o (rng_code),
    .osc_en_o   (osc_en_o),
    .stage_cnt_o(stage_cnt_o),
    .bad_o      (ctrl_bad)
  );

  // drive-strength registers
  logic [FLD_W-1:0]   fld_wr;
  logic [FLD_W-1:0]   drv_fld [NUM_DRV];
  logic [NUM_DRV-1:0] drv_bad;

  for (genvar s = 0; s < STAGES_PER_REG; s++) begin : g_pack
    assign fld_wr[s*FIELD_W +: FIELD_W] = wdata_i[s*FIELD_STRIDE +: FIELD_W];
  end

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    osc_drive_reg #(
      .STAGES (STAGES_PER_REG),
      .FIELD_W(FIELD_W),
      .KEY_W  (KEY_W),
      .KEY    (DRV_KEY)
    ) u_drv (
      .clk_i  (clk_i),
      .rst_n_i(rst_n),
      .wr_i   (wr_en_i & hit_drv[g]),
      .key_i  (wdata_i[31 -: KEY_W]),
      .fld_i  (fld_wr),
      .fld_o  (drv_fld[g]),
      .lvl_o  (drive_lvl_o[g*STAGES_PER_REG*LVL_W +: STAGES_PER_REG*LVL_W]),
      .bad_o  (drv_bad[g])
    );
  end

  // status
  logic bad_flag, stable, clr_req;
  assign clr_req = wr_en_i & hit_stat & wdata_i[STAT_BAD_BIT];

  osc_status #(.STABLE_CYC(STABLE_CYC)) u_stat (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .osc_en_i  (osc_en_o),
    .bad_evt_i (ctrl_bad | (|drv_bad)),
    .clr_i     (clr_req),
    .bad_flag_o(bad_flag),
    .stable_o  (stable)
  );

  // registered read path
  logic [31:0] rdata_q, rdata_nxt;

  always_comb begin
    rdata_nxt = '0;
    if (hit_ctrl) begin
      rdata_nxt[2*CODE_W-1:0] = {en_code, rng_code};
    end
    if (hit_stat) begin
      rdata_nxt[STAT_STABLE_BIT] = stable;
      rdata_nxt[STAT_BAD_BIT]    = bad_flag;
      rdata_nxt[STAT_RUN_BIT]    = osc_en_o;
      rdata_nxt[STAT_EN_BIT]     = osc_en_o;
    end
    for (int i = 0; i < NUM_DRV; i++) begin
      if (hit_drv[i]) begin
        for (int s = 0; s < STAGES_PER_REG; s++)
          rdata_nxt[s*FIELD_STRIDE +: FIELD_W] = drv_fld[i][s*FIELD_W +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rdata_q <= '0;
    else          rdata_q <= rdata_nxt;
  end

  assign rdata_o = rdata_q;

  assert_unmapped_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mapped |=> (rdata_o == '0));

  assert_stat_read_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit_stat |=> (rdata_o[STAT_BAD_BIT] == $past(bad_flag)));

endmodule

// File: tb/osc_cfg_regs_tb_top.sv
module osc_cfg_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        osc_en;
  logic [3:0]  stage_cnt;
  logic [15:0] drive_lvl;

  always #2 clk = ~clk;

  osc_cfg_regs dut_i (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .osc_en_o   (osc_en),
    .stage_cnt_o(stage_cnt),
    .drive_lvl_o(drive_lvl)
  );

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  logic  rd_req = 1'b0;
  logic  rd_req_d = 1'b0;
  logic  done = 1'b0;

  localparam logic [31:0] ST_BAD = 32'h0100_0000;
  localparam logic [31:0] ST_EN  = 32'h0001_1000;
  localparam logic [31:0] ST_STB = 32'h8000_0000;
  localparam logic [31:0] ALL    = 32'hFFFF_FFFF;

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: compare read data one edge after the request
  always @(negedge clk) begin
    if (rd_req_d) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if ((rdata & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h (mask %h)", it.tag, rdata, it.exp, it.mask);
      end
    end
  end

  // driver: one bus cycle, called and returning at a falling edge
  task automatic bus(input logic [3:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic [31:0] e, input logic [31:0] m,
                     input string t);
    addr  = a;
    wr_en = w;
    wdata = d;
    rd_req = r;
    if (r) q.push_back('{e, m, t});
    @(negedge clk);
    wr_en  = 1'b0;
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus(a, 1'b1, d, 1'b0, '0, '0, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input logic [31:0] m,
                    input string t);
    bus(a, 1'b0, '0, 1'b1, e, m, t);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic [11:0] e, input logic [11:0] r);
    return {8'h00, e, r};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr  = '0;
    wr_en = 1'b0;
    wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 osc_en", {31'b0, osc_en}, 32'h1);
    chk("R1 stage_cnt", {28'b0, stage_cnt}, 32'd8);
    chk("R1 drive_lvl", {16'b0, drive_lvl}, 32'h0);
    rd(4'h0, ctl(12'hFAB, 12'hFA4), ALL, "R1 ctrl readback");
    rd(4'h4, ST_EN, ST_BAD | ST_EN, "R1 status flag clear");

    // R3 range codes
    wr(4'h0, ctl(12'hFAB, 12'hFA5));
    chk("R3 medium", {28'b0, stage_cnt}, 32'd6);
    wr(4'h0, ctl(12'hFAB, 12'hFA7));
    chk("R3 high", {28'b0, stage_cnt}, 32'd4);
    rd(4'h0, ctl(12'hFAB, 12'hFA7), ALL, "R3 high readback");
    wr(4'h0, ctl(12'hFAB, 12'hFA6));
    chk("R3 top", {28'b0, stage_cnt}, 32'd2);
    wr(4'h0, ctl(12'hFAB, 12'hFA4));
    chk("R3 low", {28'b0, stage_cnt}, 32'd8);
    rd(4'h4, 32'h0, ST_BAD, "R3 legal codes leave flag clear");

    // R5 / R6 keyed drive writes
    wr(4'h8, 32'h9696_F318);
    wr(4'hC, 32'h9696_2461);
    chk("R6 drive levels", {16'b0, drive_lvl}, 32'h0000_59E4);
    rd(4'h8, 32'h0000_7310, ALL, "R5 drive0 readback");
    rd(4'hC, 32'h0000_2461, ALL, "R5 drive1 readback");
    rd(4'h4, 32'h0, ST_BAD, "R5 good key leaves flag clear");

    // R7 wrong key
    wr(4'h8, 32'h9695_7777);
    chk("R7 drive0 cleared, drive1 kept", {16'b0, drive_lvl}, 32'h0000_5900);
    rd(4'h8, 32'h0, ALL, "R7 drive0 readback");
    rd(4'h4, ST_BAD, ST_BAD, "R7 flag set");

    // R8 sticky flag and clear, collision with a read of status
    wr(4'h4, 32'hFEFF_FFFF);
    rd(4'h4, ST_BAD, ST_BAD, "R8 write without bit24 keeps flag");
    bus(4'h4, 1'b1, ST_BAD, 1'b1, ST_BAD, ST_BAD, "R10 status read during clear sees old");
    rd(4'h4, 32'h0, ST_BAD, "R8 flag cleared");

    // R2 enable codes
    wr(4'h0, ctl(12'hD1E, 12'hFA4));
    chk("R2 disable", {31'b0, osc_en}, 32'h0);
    rd(4'h4, 32'h0, ST_EN | ST_STB | ST_BAD, "R9 status while disabled");
    wr(4'h0, ctl(12'h123, 12'hFA4));
    chk("R2 unknown code enables", {31'b0, osc_en}, 32'h1);
    rd(4'h0, ctl(12'hFAB, 12'hFA4), ALL, "R2 unknown code reads as enable");
    rd(4'h4, ST_BAD | ST_EN, ST_BAD | ST_EN | ST_STB, "R2 flag set, R9 not yet stable");
    repeat (20) @(negedge clk);
    rd(4'h4, ST_STB | ST_EN, ST_STB | ST_EN, "R9 stable after settle");
    wr(4'h4, ST_BAD);

    // R4 unknown range, collision of bad ctrl write with a ctrl read
    wr(4'h0, ctl(12'hFAB, 12'hFA6));
    chk("R4 setup top", {28'b0, stage_cnt}, 32'd2);
    bus(4'h0, 1'b1, ctl(12'hFAB, 12'h555), 1'b1, ctl(12'hFAB, 12'hFA6), ALL,
        "R10 ctrl read during write sees old");
    chk("R4 fallback to low", {28'b0, stage_cnt}, 32'd8);
    rd(4'h0, ctl(12'hFAB, 12'hFA4), ALL, "R4 readback low");
    rd(4'h4, ST_BAD, ST_BAD, "R4 flag set");

    // R10 unmapped address
    wr(4'h1, 32'h9696_7777);
    wr(4'h2, ctl(12'hD1E, 12'hFA5));
    rd(4'h1, 32'h0, ALL, "R10 unmapped reads zero");
    chk("R10 unmapped write ignored en", {31'b0, osc_en}, 32'h1);
    chk("R10 unmapped write ignored drive", {16'b0, drive_lvl}, 32'h0000_5900);
    rd(4'h0, ctl(12'hFAB, 12'hFA4), ALL, "R10 ctrl unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule